// File: doc/BRIEF.md
# Write Auto-Precharge Bank Timing Tracker

This block follows the decoded SDRAM command stream of a memory controller, one command per clock, and keeps a small state machine per bank that models what the device does on its own after a burst write that asks for auto-precharge. From the burst length and the configured write-recovery time, it works out the cycle in which the bank closes itself. From the precharge time, it works out the first cycle in which the bank may be opened again. A read or write to a different bank that arrives while the burst is still moving data cuts the burst short. The closed bank's precharge is then counted from that command.

The controller can use the per-bank ready vector to gate its next ACTIVE. It can use the three violation pulses to catch scheduling mistakes in simulation or in the field. Configuration (burst length, write recovery, precharge time and activate-to-write delay) is given as clock counts on static inputs.

Top module: `sdram_wap_tracker`

## Requirements
- R1: While reset is high and in the first cycle after it, every bank reads state 0, every ready bit is 1 and all three violation outputs are 0.
- R2: Commands are encoded on `cmd_i` as 00 NOP, 01 ACTIVE, 10 READ, 11 WRITE. Each bank's 2-bit state sits at `bank_state_o[2b+1:2b]` with 0 = IDLE, 1 = ACTIVE, 2 = WRITING_AP, 3 = PRECHARGING. An ACTIVE to an IDLE bank shows state 1 from the next cycle. A READ or WRITE to an IDLE bank changes nothing and flags nothing.
- R3: A WRITE with `ap_i` low leaves an ACTIVE bank in state 1. A WRITE with `ap_i` high to an ACTIVE bank in cycle n shows state 2 from cycle n+1, or state 3 at once if BL+tDPL-1 equals 1.
- R4: Without interruption, the bank shows state 3 from cycle n+BL-1+tDPL and state 0, with its ready bit high, from cycle n+BL-1+tDPL+tRP.
- R5: A READ or WRITE to another bank in cycle m, with n < m <= n+BL-1, starts the precharge in cycle m. The bank shows state 3 from m+1 and state 0 from m+tRP. If that command is itself a WRITE with auto-precharge, its own bank starts its tracking in the same cycle.
- R6: A READ or WRITE to another bank after the burst's last data cycle (m >= n+BL) leaves the first bank's timing unchanged.
- R7: An ACTIVE to a bank that is not IDLE sets `err_act_o` in the next cycle and leaves the bank's state unchanged. An ACTIVE in the first ready cycle is accepted without a flag.
- R8: A READ or WRITE to a bank in state 2 or 3 sets `err_same_o` in the next cycle and leaves that bank's timing unchanged.
- R9: A WRITE to an ACTIVE bank fewer than tRCD cycles after its ACTIVE sets `err_trcd_o` in the next cycle and still takes effect. A WRITE exactly tRCD cycles after the ACTIVE raises no flag.
- R10: The violation outputs are one-cycle pulses. They stay 0 in the cycle after any legal command, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_i | input | 2 | Decoded command (NOP, ACTIVE, READ, WRITE) |
| ba_i | input | BAW | Bank address of the command |
| ap_i | input | 1 | Auto-precharge address bit of a WRITE |
| cfg_bl_i | input | CW | Burst length in clocks |
| cfg_tdpl_i | input | CW | Last data-in to precharge delay in clocks |
| cfg_trp_i | input | CW | Precharge time in clocks |
| cfg_trcd_i | input | CW | ACTIVE to WRITE delay in clocks |
| bank_ready_o | output | 2**BAW | Per-bank: an ACTIVE is legal this cycle |
| bank_state_o | output | 2*2**BAW | Per-bank 2-bit state |
| err_act_o | output | 1 | ACTIVE to a bank that is not IDLE |
| err_same_o | output | 1 | Access to a bank under auto-precharge |
| err_trcd_o | output | 1 | WRITE issued before tRCD elapsed |

## Verification
A bank's own countdown and a command to another bank can act on it in the same edge. The critical case is an other-bank READ or WRITE landing in the last data cycle of a burst, just before the natural precharge start, or one cycle after it, when it must no longer matter. The bench sweeps burst length, tDPL and tRP over small ranges and issues the other-bank access at every offset from 1 to 6 after the auto-precharge write. For every cycle it computes the expected state arithmetically from the offset and the timing parameters. A separate case puts a second auto-precharge write on the interrupting command, so that one bank starts precharging in the same cycle as the other begins its burst.

// File: rtl/sdram_wap_tracker.sv
module sdram_wap_tracker #(
  parameter int BAW = 2,
  parameter int CW  = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [1:0]            cmd_i,
  input  logic [BAW-1:0]        ba_i,
  input  logic                  ap_i,
  input  logic [CW-1:0]         cfg_bl_i,
  input  logic [CW-1:0]         cfg_tdpl_i,
  input  logic [CW-1:0]         cfg_trp_i,
  input  logic [CW-1:0]         cfg_trcd_i,
  output logic [2**BAW-1:0]     bank_ready_o,
  output logic [2*(2**BAW)-1:0] bank_state_o,
  output logic                  err_act_o,
  output logic                  err_same_o,
  output logic                  err_trcd_o
);
  localparam int NB   = 2**BAW;
  localparam int CNTW = CW + 1;

  localparam logic [1:0] C_NOP = 2'd0, C_ACT = 2'd1, C_WR = 2'd3;
  localparam logic [1:0] S_IDLE = 2'd0, S_ACT = 2'd1, S_WAP = 2'd2, S_PRE = 2'd3;

  logic [1:0]      st_q  [NB];
  logic [CNTW-1:0] cnt_q [NB];
  logic [CW-1:0]   rcd_q [NB];
  logic            err_act_q, err_same_q, err_trcd_q;

  logic            is_act, is_rw, is_wr;
  logic [1:0]      tgt_st;
  logic [NB-1:0]   sel, intr;
  logic [CNTW-1:0] k_wap, trp_x, tdpl_x;

  assign is_act = (cmd_i == C_ACT);
  assign is_wr  = (cmd_i == C_WR);
  assign is_rw  = cmd_i[1];
  assign tgt_st = st_q[ba_i];
  assign trp_x  = {1'b0, cfg_trp_i};
  assign tdpl_x = {1'b0, cfg_tdpl_i};
  assign k_wap  = {1'b0, cfg_bl_i} + tdpl_x - CNTW'(1);

  always_comb begin
    for (int b = 0; b < NB; b++) begin
      sel[b]  = (ba_i == BAW'(b));
      intr[b] = is_rw && !sel[b] && (st_q[b] == S_WAP) && (cnt_q[b] >= tdpl_x);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < NB; b++) begin
        st_q[b]  <= S_IDLE;
        cnt_q[b] <= '0;
        rcd_q[b] <= '0;
      end
      err_act_q  <= 1'b0;
      err_same_q <= 1'b0;
      err_trcd_q <= 1'b0;
    end else begin
      err_act_q  <= is_act && (tgt_st != S_IDLE);
      err_same_q <= is_rw && (tgt_st == S_WAP || tgt_st == S_PRE);
      err_trcd_q <= is_wr && (tgt_st == S_ACT) && (rcd_q[ba_i] != '0);
      for (int b = 0; b < NB; b++) begin
        if (rcd_q[b] != '0) rcd_q[b] <= rcd_q[b] - CW'(1);
        case (st_q[b])
          S_IDLE: begin
            if (is_act && sel[b]) begin
              st_q[b]  <= S_ACT;
              rcd_q[b] <= cfg_trcd_i - CW'(1);
            end
          end
          S_ACT: begin
            if (is_wr && sel[b] && ap_i) begin
              if (k_wap <= CNTW'(1)) begin
                st_q[b]  <= S_PRE;
                cnt_q[b] <= trp_x;
              end else begin
                st_q[b]  <= S_WAP;
                cnt_q[b] <= k_wap - CNTW'(1);
              end
            end
          end
          S_WAP: begin
            if (intr[b]) begin
              if (trp_x <= CNTW'(1)) begin
                st_q[b]  <= S_IDLE;
                cnt_q[b] <= '0;
              end else begin
                st_q[b]  <= S_PRE;
                cnt_q[b] <= trp_x - CNTW'(1);
              end
            end else if (cnt_q[b] <= CNTW'(1)) begin
              st_q[b]  <= S_PRE;
              cnt_q[b] <= trp_x;
            end else begin
              cnt_q[b] <= cnt_q[b] - CNTW'(1);
            end
          end
          default: begin
            if (cnt_q[b] <= CNTW'(1)) begin
              st_q[b]  <= S_IDLE;
              cnt_q[b] <= '0;
            end else begin
              cnt_q[b] <= cnt_q[b] - CNTW'(1);
            end
          end
        endcase
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < NB; g++) begin : g_out
      assign bank_state_o[2*g +: 2] = st_q[g];
      assign bank_ready_o[g]        = (st_q[g] == S_IDLE);

      // R7
      act_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q[g] == S_WAP || st_q[g] == S_PRE) |=> (st_q[g] != S_ACT));

      // R8
      same_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q[g] == S_WAP && is_rw && sel[g] && cnt_q[g] > CNTW'(1)) |=> (st_q[g] == S_WAP));

      // R4
      pre_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q[g] == S_PRE) |=> (st_q[g] == S_PRE || st_q[g] == S_IDLE));

      // R5
      intr_close_chk: assert property (@(posedge clk) disable iff (rst)
        (intr[g] && trp_x > CNTW'(1)) |=> (st_q[g] == S_PRE && bank_ready_o[g] == 1'b0));

      // R3
      wap_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q[g] == S_WAP) |-> (cnt_q[g] != '0));
    end
  endgenerate

  assign err_act_o  = err_act_q;
  assign err_same_o = err_same_q;
  assign err_trcd_o = err_trcd_q;

  // R10
  err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({err_act_o, err_same_o, err_trcd_o}));

  // R9
  err_trcd_src_chk: assert property (@(posedge clk) disable iff (rst)
    err_trcd_o |-> ($past(cmd_i) == C_WR));

  // R2
  nop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_i == C_NOP) |=> !(err_act_o || err_same_o || err_trcd_o));
endmodule

// File: tb/sdram_wap_tracker_tb_top.sv
`timescale 1ns/1ps
module sdram_wap_tracker_tb_top;
  localparam logic [1:0] NOP = 2'd0, ACT = 2'd1, RD = 2'd2, WR = 2'd3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cmd_i = NOP;
  logic [1:0] ba_i = '0;
  logic       ap_i = 1'b0;
  logic [2:0] cfg_bl_i = 3'd2, cfg_tdpl_i = 3'd2, cfg_trp_i = 3'd2, cfg_trcd_i = 3'd2;
  logic [3:0] bank_ready_o;
  logic [7:0] bank_state_o;
  logic       err_act_o, err_same_o, err_trcd_o;

  int vecs = 0;
  int errs = 0;

  always #2.5 clk = ~clk;

  sdram_wap_tracker dut_i (
    .clk(clk), .rst(rst), .cmd_i(cmd_i), .ba_i(ba_i), .ap_i(ap_i),
    .cfg_bl_i(cfg_bl_i), .cfg_tdpl_i(cfg_tdpl_i), .cfg_trp_i(cfg_trp_i), .cfg_trcd_i(cfg_trcd_i),
    .bank_ready_o(bank_ready_o), .bank_state_o(bank_state_o),
    .err_act_o(err_act_o), .err_same_o(err_same_o), .err_trcd_o(err_trcd_o)
  );

  task automatic chk(input int got, input int exp, input string req);
    vecs++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %0d expected %0d (t=%0t)", req, got, exp, $time);
    end
  endtask

  function automatic int st(input int b);
    return int'(bank_state_o[2*b +: 2]);
  endfunction

  function automatic int errv();
    return int'({err_act_o, err_same_o, err_trcd_o});
  endfunction

  task automatic drive(input logic [1:0] c, input logic [1:0] b, input logic a);
    cmd_i = c; ba_i = b; ap_i = a;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; cmd_i = NOP; ba_i = '0; ap_i = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    int bls[3];
    bls = '{1, 2, 4};

    // R1: reset state
    do_reset();
    chk(int'(bank_ready_o), 15, "R1 ready");
    chk(int'(bank_state_o), 0, "R1 state");
    chk(errv(), 0, "R1 errors");

    // Directed case: BL=2, tDPL=2, tRP=2, tRCD=2
    drive(ACT, 2'd0, 1'b0);
    chk(st(0), 1, "R2 active");
    chk(errv(), 0, "R10 legal active");
    drive(ACT, 2'd0, 1'b0);
    chk(errv(), 4, "R7 active to open bank");
    chk(st(0), 1, "R7 state kept");
    drive(WR, 2'd0, 1'b1);           // n: exactly tRCD after ACTIVE
    chk(errv(), 0, "R9 write at tRCD");
    chk(st(0), 2, "R3 writing_ap");
    drive(WR, 2'd0, 1'b0);           // n+1 same-bank access
    chk(errv(), 2, "R8 same bank flag");
    chk(st(0), 2, "R8 state kept");
    drive(NOP, 2'd0, 1'b0);          // n+3
    chk(st(0), 3, "R8 precharge on time");
    chk(errv(), 0, "R10 pulse cleared");
    drive(ACT, 2'd0, 1'b0);          // n+4
    chk(errv(), 4, "R7 early active");
    chk(st(0), 3, "R7 precharge kept");
    drive(NOP, 2'd0, 1'b0);          // n+5
    chk(st(0), 0, "R4 idle at tDAL");
    chk(int'(bank_ready_o[0]), 1, "R4 ready at tDAL");
    drive(ACT, 2'd0, 1'b0);          // n+6
    chk(st(0), 1, "R7 active in first ready cycle");
    chk(errv(), 0, "R7 no flag");
    drive(ACT, 2'd2, 1'b0);
    drive(WR, 2'd2, 1'b0);
    chk(errv(), 1, "R9 early write");
    chk(st(2), 1, "R9 write effective");
    drive(RD, 2'd3, 1'b0);
    chk(st(3), 0, "R2 read to idle bank");
    chk(errv(), 0, "R2 no flag on idle access");

    // R5: interrupting command is itself a write with auto-precharge
    do_reset();
    drive(ACT, 2'd0, 1'b0);
    drive(ACT, 2'd1, 1'b0);
    drive(NOP, 2'd0, 1'b0);
    drive(NOP, 2'd0, 1'b0);
    drive(WR, 2'd0, 1'b1);           // n
    drive(WR, 2'd1, 1'b1);           // n+1
    chk(st(0), 3, "R5 bank0 precharging");
    chk(st(1), 2, "R5 bank1 writing");
    drive(NOP, 2'd0, 1'b0);          // n+3
    chk(st(0), 0, "R5 bank0 idle after tRP");
    chk(st(1), 2, "R5 bank1 still writing");
    drive(NOP, 2'd0, 1'b0);          // n+4
    chk(st(1), 3, "R5 bank1 precharging");
    drive(NOP, 2'd0, 1'b0);
    drive(NOP, 2'd0, 1'b0);          // n+6
    chk(st(1), 0, "R5 bank1 idle");

    // Sweep: BL x tDPL x tRP x interrupt offset (0 = none)
    foreach (bls[i]) begin
      for (int tdpl = 1; tdpl <= 3; tdpl++) begin
        for (int trp = 1; trp <= 3; trp++) begin
          for (int o = 0; o <= 6; o++) begin
            int k;
            bit inter;
            cfg_bl_i = 3'(bls[i]); cfg_tdpl_i = 3'(tdpl); cfg_trp_i = 3'(trp); cfg_trcd_i = 3'd2;
            do_reset();
            drive(ACT, 2'd0, 1'b0);
            drive(ACT, 2'd1, 1'b0);
            drive(NOP, 2'd0, 1'b0);
            drive(NOP, 2'd0, 1'b0);
            drive(WR, 2'd0, 1'b1);
            k = bls[i] - 1 + tdpl;
            inter = (o >= 1) && (o <= bls[i] - 1);
            for (int j = 1; j <= 16; j++) begin
              int e;
              if (inter) e = (j <= o) ? 2 : (j < o + trp) ? 3 : 0;
              else       e = (j < k) ? 2 : (j < k + trp) ? 3 : 0;
              chk(st(0), e, inter ? "R5 interrupted timing" : "R4 R6 natural timing");
              chk(int'(bank_ready_o[0]), (e == 0) ? 1 : 0, "R4 ready bit");
              chk(st(1), 1, "R3 plain write keeps bank open");
              chk(errv(), 0, "R10 no flag on legal stream");
              if (j == o) drive((o % 2 == 1) ? RD : WR, 2'd1, 1'b0);
              else        drive(NOP, 2'd0, 1'b0);
            end
          end
        end
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    errs++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule